// File: doc/BRIEF.md
# Watchdog Timer with Selectable Period

This block guards a bus-attached single-board computer against a hung processor. Software selects one of three timeout periods, or turns the watchdog off, through a two-bit period field. Counting is done in units of a one-cycle time-base tick. The count is restarted by any read of the module status/control register, so a routine status poll keeps the board alive without a dedicated kick write.

When the count reaches the selected terminal count, the block does four things in the same cycle:
- it latches a sticky watchdog flag that survives the warm reset it causes;
- it sends a one-cycle event to the interrupt logic;
- it sets a system-failure output;
- it requests a local warm reset from the reset sequencer.

A warm reset that comes from any other source forces the period field to off, so the watchdog cannot expire on the way out of that reset. A soft-reset hold input keeps the counter at zero while it is asserted.

Top module: `wdog_timer`

## Requirements
- R1: Period code 2'b00 disables the watchdog: no event, reset request, flag or failure output arises, however many ticks arrive.
- R2: Codes 2'b01, 2'b10 and 2'b11 expire after exactly TC_LONG, TC_SHORT and TC_MID ticks since the last restart. At the clock edge that samples the terminal tick, wd_event_o and warm_req_o pulse high and wd_flag_o and sysfail_o are set.
- R3: A cycle with stat_rd_i high restarts the count from zero. A tick in that same cycle is not counted.
- R4: wd_event_o and warm_req_o are high for a single cycle per expiry. Counting then restarts from zero with the period kept, so expiries repeat every terminal count of ticks.
- R5: wd_flag_o, which is bit 3 of the status register, is sticky. It is cleared only by rst_n or by a status write (sts_we_i) with sts_flag_wd_i equal to 1. A write of 0 has no effect, and a new expiry in the same cycle as a clearing write leaves the flag set.
- R6: warm_rst_i forces period_o to 2'b00 and clears the count, and it wins over a simultaneous period write. It leaves wd_flag_o unchanged.
- R7: While soft_hold_i is high, the counter is held at zero and cannot expire. After release, counting resumes from zero with the period kept.
- R8: A period write of a non-zero value that differs from the current one restarts the count. A write of the current value does not.
- R9: sysfail_o stays set after an expiry until a period write of a non-zero value. Neither a flag clear nor a write of 2'b00 clears it.
- R10: After rst_n, period_o is 2'b00 and all other outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| stat_rd_i | input | 1 | Read strobe of the status/control register |
| soft_hold_i | input | 1 | Soft reset: holds the counter cleared |
| warm_rst_i | input | 1 | Warm reset from a source other than this watchdog |
| cfg_we_i | input | 1 | Period field write strobe |
| cfg_wdata_i | input | 2 | Period field write data |
| sts_we_i | input | 1 | Status write strobe |
| sts_flag_wd_i | input | 1 | Write data for status bit 3 (1 clears the flag) |
| period_o | output | 2 | Current period field |
| wd_event_o | output | 1 | Watchdog event pulse to interrupt logic |
| wd_flag_o | output | 1 | Sticky watchdog-expired flag |
| sysfail_o | output | 1 | System-failure output |
| warm_req_o | output | 1 | Local warm reset request pulse |

## Verification
The bench builds the block with TC_LONG=12, TC_SHORT=3 and TC_MID=6. With these values every period code, including off, can be swept through two full expiry cycles tick by tick, and each tick is compared with an arithmetic count model. The short periods also make it cheap to line up corner cases on exact cycles:
- a read or a hold coinciding with a tick;
- a same-value and a different-value period rewrite partway through a count;
- a flag-clearing write landing on the terminal tick;
- warm reset and flag clearing checked through period_o and wd_flag_o.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    PER_OFF   = 2'b00,
    PER_LONG  = 2'b01,
    PER_SHORT = 2'b10,
    PER_MID   = 2'b11
  } per_e;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warm_rst_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_wdata_i,
  output per_e       period_o,
  output logic       rearm_o,
  output logic       clr_fail_o
);
  per_e period_q, period_d;
  logic period_en;
  logic wr_ok;

  // a period write is accepted only when no external warm reset is present
  assign wr_ok = cfg_we_i && !warm_rst_i;

  always_comb begin
    period_d  = period_q;
    period_en = 1'b0;
    if (warm_rst_i) begin
      period_d  = PER_OFF;
      period_en = 1'b1;
    end else if (cfg_we_i) begin
      period_d  = per_e'(cfg_wdata_i);
      period_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PER_OFF;
    end else if (period_en) begin
      period_q <= period_d;
    end
  end

  assign rearm_o    = wr_ok && (cfg_wdata_i != 2'b00) && (cfg_wdata_i != period_q);
  assign clr_fail_o = wr_ok && (cfg_wdata_i != 2'b00);
  assign period_o   = period_q;

  // R6: an external warm reset leaves the watchdog disabled
  assert_warm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_i |=> (period_q == PER_OFF));
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
  import wdog_pkg::*;
#(
  parameter int CW       = 14,
  parameter int TC_LONG  = 8192,
  parameter int TC_SHORT = 128,
  parameter int TC_MID   = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  per_e period_i,
  input  logic tick_i,
  input  logic restart_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam logic [CW-1:0] LAST_LONG  = CW'(TC_LONG - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(TC_SHORT - 1);
  localparam logic [CW-1:0] LAST_MID   = CW'(TC_MID - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;
  logic          en;
  logic          at_last;
  logic          cnt_en;

  always_comb begin
    unique case (period_i)
      PER_LONG:  last = LAST_LONG;
      PER_SHORT: last = LAST_SHORT;
      PER_MID:   last = LAST_MID;
      default:   last = '0;
    endcase
  end

  assign en      = (period_i != PER_OFF);
  assign at_last = (cnt_q == last);

  always_comb begin
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    expire_o = 1'b0;
    if (restart_i || hold_i || !en) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (tick_i) begin
      cnt_en = 1'b1;
      if (at_last) begin
        cnt_d    = '0;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: an armed count never passes its terminal value
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= last));
  // R7: hold leaves the counter at zero
  assert_hold_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_flag.sv
module wdog_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic sts_we_i,
  input  logic sts_flag_wd_i,
  input  logic clr_fail_i,
  output logic flag_o,
  output logic fail_o,
  output logic event_o,
  output logic req_o
);
  logic flag_q, flag_d, fail_q, fail_d;
  logic event_q, req_q;
  logic flag_clr;

  assign flag_clr = sts_we_i && sts_flag_wd_i;

  always_comb begin
    flag_d = flag_q;
    if (expire_i)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    fail_d = fail_q;
    if (expire_i)        fail_d = 1'b1;
    else if (clr_fail_i) fail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      fail_q  <= 1'b0;
      event_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      fail_q  <= fail_d;
      event_q <= expire_i;
      req_q   <= expire_i;
    end
  end

  assign flag_o  = flag_q;
  assign fail_o  = fail_q;
  assign event_o = event_q;
  assign req_o   = req_q;

  // R5: the flag only falls on a clearing write
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  // R2: an event is always accompanied by the flag
  assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    event_q |-> flag_q);
  // R9: an event is always accompanied by the failure output
  assert_event_sets_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    event_q |-> fail_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int TC_LONG  = 8192,
  parameter int TC_SHORT = 128,
  parameter int TC_MID   = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       stat_rd_i,
  input  logic       soft_hold_i,
  input  logic       warm_rst_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_wdata_i,
  input  logic       sts_we_i,
  input  logic       sts_flag_wd_i,
  output logic [1:0] period_o,
  output logic       wd_event_o,
  output logic       wd_flag_o,
  output logic       sysfail_o,
  output logic       warm_req_o
);
  localparam int TC_A   = (TC_LONG > TC_SHORT) ? TC_LONG : TC_SHORT;
  localparam int TC_MAX = (TC_A > TC_MID) ? TC_A : TC_MID;
  localparam int CW     = (TC_MAX > 1) ? $clog2(TC_MAX) : 1;

  per_e period;
  logic rearm, clr_fail, expire, restart;

  assign restart = stat_rd_i || rearm || warm_rst_i;

  wdog_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst_i (warm_rst_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .period_o   (period),
    .rearm_o    (rearm),
    .clr_fail_o (clr_fail)
  );

  wdog_cnt #(
    .CW      (CW),
    .TC_LONG (TC_LONG),
    .TC_SHORT(TC_SHORT),
    .TC_MID  (TC_MID)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period),
    .tick_i   (tick_i),
    .restart_i(restart),
    .hold_i   (soft_hold_i),
    .expire_o (expire)
  );

  wdog_flag u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .expire_i     (expire),
    .sts_we_i     (sts_we_i),
    .sts_flag_wd_i(sts_flag_wd_i),
    .clr_fail_i   (clr_fail),
    .flag_o       (wd_flag_o),
    .fail_o       (sysfail_o),
    .event_o      (wd_event_o),
    .req_o        (warm_req_o)
  );

  assign period_o = period;

  // R1: a disabled watchdog raises no event in the following cycle
  assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (period == PER_OFF) |=> !wd_event_o);
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int TL = 12;
  localparam int TS = 3;
  localparam int TM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rd = 1'b0, hold = 1'b0, warm = 1'b0;
  logic cfg_we = 1'b0, sts_we = 1'b0, sts_wd = 1'b0;
  logic [1:0] cfg_wd = 2'b00;
  logic [1:0] per;
  logic ev, flag, fail, req;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mcnt = 0;
  int mtc = 0;
  logic [1:0] cur = 2'b00;

  always #4 clk = ~clk;

  wdog_timer #(.TC_LONG(TL), .TC_SHORT(TS), .TC_MID(TM)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .stat_rd_i(rd),
    .soft_hold_i(hold), .warm_rst_i(warm), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wd), .sts_we_i(sts_we), .sts_flag_wd_i(sts_wd),
    .period_o(per), .wd_event_o(ev), .wd_flag_o(flag),
    .sysfail_o(fail), .warm_req_o(req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tc_of(input logic [1:0] c);
    case (c)
      2'b01:   return TL;
      2'b10:   return TS;
      2'b11:   return TM;
      default: return 0;
    endcase
  endfunction

  // one tick cycle; event expected from the arithmetic model
  task automatic do_tick(input string tag);
    int e;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    mcnt++;
    e = (mtc != 0 && mcnt == mtc) ? 1 : 0;
    if (e == 1) mcnt = 0;
    chk({tag, " event"}, int'(ev), e);
    chk({tag, " req"}, int'(req), e);
  endtask

  task automatic do_cfg(input logic [1:0] c);
    cfg_we = 1'b1; cfg_wd = c;
    @(negedge clk);
    cfg_we = 1'b0;
    if (c != cur || c == 2'b00) mcnt = 0;
    cur = c; mtc = tc_of(c);
  endtask

  task automatic do_warm();
    warm = 1'b1;
    @(negedge clk);
    warm = 1'b0;
    cur = 2'b00; mtc = 0; mcnt = 0;
  endtask

  task automatic do_sts(input logic b);
    sts_we = 1'b1; sts_wd = b;
    @(negedge clk);
    sts_we = 1'b0; sts_wd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 period", int'(per), 0);
    chk("R10 event", int'(ev), 0);
    chk("R10 flag", int'(flag), 0);
    chk("R10 fail", int'(fail), 0);
    chk("R10 req", int'(req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release flag", int'(flag), 0);

    // R1 R2 R4: sweep every period code over two expiry cycles
    for (int c = 0; c < 4; c++) begin
      int n;
      do_warm();
      do_sts(1'b1);
      do_cfg(c[1:0]);
      chk("R2 period readback", int'(per), c);
      n = (c == 0) ? 30 : 2 * tc_of(c[1:0]);
      for (int i = 0; i < n; i++) begin
        do_tick((c == 0) ? "R1" : "R2");
        if (mcnt == 0 && c != 0) begin
          @(negedge clk);
          chk("R4 single-cycle event", int'(ev), 0);
          chk("R4 single-cycle req", int'(req), 0);
        end
      end
      chk((c == 0) ? "R1 flag" : "R2 flag", int'(flag), (c == 0) ? 0 : 1);
      chk((c == 0) ? "R1 fail" : "R2 fail", int'(fail), (c == 0) ? 0 : 1);
    end

    // R5: flag clearing rules; R6: warm reset keeps the flag, disables
    do_sts(1'b0);
    chk("R5 write 0 keeps flag", int'(flag), 1);
    do_warm();
    chk("R6 period off", int'(per), 0);
    chk("R6 flag kept", int'(flag), 1);
    for (int i = 0; i < 15; i++) do_tick("R6");
    do_sts(1'b1);
    chk("R5 write 1 clears", int'(flag), 0);
    // R9: failure output survives flag clear and off write
    chk("R9 fail after clear", int'(fail), 1);
    do_cfg(2'b00);
    chk("R9 fail after off write", int'(fail), 1);
    do_cfg(2'b10);
    chk("R9 fail cleared by arm", int'(fail), 0);

    // R6: warm reset wins over a simultaneous write
    warm = 1'b1; cfg_we = 1'b1; cfg_wd = 2'b11;
    @(negedge clk);
    warm = 1'b0; cfg_we = 1'b0;
    cur = 2'b00; mtc = 0; mcnt = 0;
    chk("R6 warm over write", int'(per), 0);

    // R3: read restarts; a tick in the read cycle is not counted
    do_cfg(2'b10);
    do_tick("R3"); do_tick("R3");
    rd = 1'b1; tick = 1'b1;
    @(negedge clk);
    rd = 1'b0; tick = 1'b0; mcnt = 0;
    chk("R3 no event on read", int'(ev), 0);
    for (int i = 0; i < TS; i++) do_tick("R3");

    // R7: hold keeps counter at zero, period kept
    do_cfg(2'b11);
    for (int i = 0; i < 4; i++) do_tick("R7");
    hold = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick = 1'b1;
      @(negedge clk);
      chk("R7 held no event", int'(ev), 0);
    end
    tick = 1'b0; hold = 1'b0; mcnt = 0;
    chk("R7 period kept", int'(per), 3);
    for (int i = 0; i < TM; i++) do_tick("R7");

    // R8: same-value rewrite keeps count, new value restarts
    do_cfg(2'b01);
    for (int i = 0; i < 10; i++) do_tick("R8");
    do_cfg(2'b01);
    do_tick("R8"); do_tick("R8");
    for (int i = 0; i < 5; i++) do_tick("R8");
    do_cfg(2'b10);
    for (int i = 0; i < TS; i++) do_tick("R8");

    // R5: expiry in the same cycle as a clearing write keeps the flag
    do_sts(1'b1);
    chk("R5 cleared before race", int'(flag), 0);
    do_tick("R5"); do_tick("R5");
    tick = 1'b1; sts_we = 1'b1; sts_wd = 1'b1;
    @(negedge clk);
    tick = 1'b0; sts_we = 1'b0; sts_wd = 1'b0; mcnt = 0;
    chk("R5 set wins event", int'(ev), 1);
    chk("R5 set wins flag", int'(flag), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule